// File: doc/BRIEF.md
# Bank-Switched Byte Data Memory with Register Decode

This block is the byte-wide data store of a small 8-bit controller core. Each instruction gives a 7-bit direct operand. A bank bit held in bit 5 of the status register supplies the top bit of the address. The same operand can therefore reach a different register, depending on what software last wrote to that bit.

The 8-bit effective address falls into one of four regions. Special registers take the first twelve slots of each bank. General-purpose RAM is 68 bytes. The bank-1 window over that RAM is a mirror of the same bytes. Everything else is a hole. The implemented registers are the status register and one 8-pin port with its direction register, so bank switching and pin control can be seen at the pins.

Writes are synchronous and take effect on the rising clock edge. Reads are combinational from the current address and bank.

The bank is held in a two-state machine:
- State `BANK_LO` selects addresses 00h–7Fh, and the transition `SELECT_HI` is taken when the status register is written with bit 5 set.
- State `BANK_HI` selects addresses 80h–FFh, and the transition `SELECT_LO` is taken when the status register is written with bit 5 clear.
- Any other cycle holds the current state.

Top module: `banked_dmem`

## Requirements
- R1: The effective address is {bank bit, addr_i[6:0]}. Operand 05h reaches the port data register in bank 0 and the direction register (85h) in bank 1.
- R2: After reset the bank bit is 0, the status register reads 00h, the direction register is FFh (pin_oe_o all 0) and the output latch is 00h (pin_out_o all 0).
- R3: The status register is at operand 03h in both banks (03h and 83h) and stores all 8 bits written to it. Its bit 5 is the bank bit. A write to it changes the bank starting with the next cycle; the read data in the write cycle still shows the old value.
- R4: General-purpose RAM holds 68 bytes at 0Ch–4Fh. A byte written there reads back unchanged.
- R5: Addresses 8Ch–CFh access the same bytes as 0Ch–4Fh.
- R6: Addresses 50h–7Fh and D0h–FFh read 00h, and writes to them change no state.
- R7: Special-register slots 00h–0Bh and 80h–8Bh other than 03h, 05h, 83h and 85h read 00h, and writes to them change no state.
- R8: Direction bit n equal to 1 makes pin n an input (pin_oe_o[n]=0). Equal to 0, it makes pin n an output (pin_oe_o[n]=1). The register reads back at 85h.
- R9: Reading 05h returns pin_in_i. Writing 05h loads the output latch, which drives pin_out_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Direct operand address |
| wr_en_i | input | 1 | Write strobe for this cycle |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read data |
| pin_in_i | input | 8 | Sampled pin levels |
| pin_out_o | output | 8 | Output latch driving the pins |
| pin_oe_o | output | 8 | Per-pin output enable (1 = driven) |

## Verification
The decode is tried with the same operands in both bank states:
- 03h, 05h, 0Ch and 4Fh show whether the bank bit reaches the right register, the mirror, or the RAM edges.
- 50h shows that the lower and upper holes stay empty.
- 04h shows that an unimplemented slot stays empty.

Several pin patterns separate a read of the pins from a read of the latch. Writing a mixed direction pattern separates inputs from outputs. Directed checks look at the reset values and at the one-cycle delay of a bank switch.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
    localparam int DATA_W = 8;
    localparam int BANK_BIT = 5;
    localparam int SFR_LAST = 11;
    localparam logic [3:0] SLOT_STATUS = 4'h3;
    localparam logic [3:0] SLOT_PORT = 4'h5;

    typedef enum logic {
        BANK_LO = 1'b0,
        BANK_HI = 1'b1
    } bank_e;

    typedef enum logic [1:0] {
        REG_SFR,
        REG_GPR,
        REG_MIRROR,
        REG_HOLE
    } region_e;
endpackage

// File: rtl/dmem_region_dec.sv
module dmem_region_dec
    import dmem_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int GPR_FIRST = 12,
    parameter int GPR_LAST = 79,
    localparam int GPR_N = GPR_LAST - GPR_FIRST + 1,
    localparam int GIDX_W = $clog2(GPR_N)
) (
    input  bank_e             bank,
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [GIDX_W-1:0] gpr_idx,
    output logic [3:0]        sfr_slot
);
    localparam logic [ADDR_W-1:0] SFR_END_A = ADDR_W'(SFR_LAST);
    localparam logic [ADDR_W-1:0] GPR_LO_A = ADDR_W'(GPR_FIRST);
    localparam logic [ADDR_W-1:0] GPR_HI_A = ADDR_W'(GPR_LAST);

    logic [ADDR_W-1:0] offset;
    assign offset = addr - GPR_LO_A;
    assign sfr_slot = addr[3:0];

    always_comb begin
        region = REG_HOLE;
        gpr_idx = '0;
        if (addr <= SFR_END_A) begin
            region = REG_SFR;
        end else if (addr >= GPR_LO_A && addr <= GPR_HI_A) begin
            region = (bank == BANK_LO) ? REG_GPR : REG_MIRROR;
            gpr_idx = GIDX_W'(offset);
        end
    end
endmodule

// File: rtl/dmem_gpr_array.sv
module dmem_gpr_array
    import dmem_pkg::*;
#(
    parameter int DEPTH = 68,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/dmem_gpio_port.sv
module dmem_gpio_port #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_we,
    input  logic              lat_we,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] dir_o,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
            lat_q <= '0;
        end else begin
            if (dir_we) dir_q <= wdata;
            if (lat_we) lat_q <= wdata;
        end
    end

    assign dir_o = dir_q;
    assign pin_out = lat_q;
    assign pin_oe = ~dir_q;

    assert_dir_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we |=> (pin_oe == ~$past(wdata)));
    assert_latch_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lat_we |=> (pin_out == $past(wdata)));
endmodule

// File: rtl/banked_dmem.sv
module banked_dmem
    import dmem_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int PORT_W = 8,
    parameter int GPR_FIRST = 12,
    parameter int GPR_LAST = 79,
    localparam int GPR_N = GPR_LAST - GPR_FIRST + 1,
    localparam int GIDX_W = $clog2(GPR_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        rd_data_o,
    input  logic [PORT_W-1:0] pin_in_i,
    output logic [PORT_W-1:0] pin_out_o,
    output logic [PORT_W-1:0] pin_oe_o
);
    localparam logic [DATA_W-1:0] BANK_MASK = DATA_W'(1) << BANK_BIT;

    bank_e             bank_q, bank_d;
    logic [DATA_W-1:0] status_q;
    region_e           region;
    logic [GIDX_W-1:0] gpr_idx;
    logic [3:0]        sfr_slot;
    logic [DATA_W-1:0] gpr_rdata;
    logic [PORT_W-1:0] dir_val;
    logic [DATA_W-1:0] status_view;
    logic              sfr_wr, st_we, lat_we, dir_we, gpr_we;

    dmem_region_dec #(
        .ADDR_W(ADDR_W), .GPR_FIRST(GPR_FIRST), .GPR_LAST(GPR_LAST)
    ) u_dec (
        .bank(bank_q), .addr(addr_i), .region(region),
        .gpr_idx(gpr_idx), .sfr_slot(sfr_slot)
    );

    assign sfr_wr = wr_en_i && (region == REG_SFR);
    assign st_we  = sfr_wr && (sfr_slot == SLOT_STATUS);
    assign lat_we = sfr_wr && (sfr_slot == SLOT_PORT) && (bank_q == BANK_LO);
    assign dir_we = sfr_wr && (sfr_slot == SLOT_PORT) && (bank_q == BANK_HI);
    assign gpr_we = wr_en_i && (region == REG_GPR || region == REG_MIRROR);

    dmem_gpr_array #(.DEPTH(GPR_N)) u_gpr (
        .clk(clk), .we(gpr_we), .idx(gpr_idx),
        .wdata(wr_data_i), .rdata(gpr_rdata)
    );

    dmem_gpio_port #(.PORT_W(PORT_W)) u_port (
        .clk(clk), .rst_n(rst_n), .dir_we(dir_we), .lat_we(lat_we),
        .wdata(wr_data_i[PORT_W-1:0]), .dir_o(dir_val),
        .pin_out(pin_out_o), .pin_oe(pin_oe_o)
    );

    // Bank state machine: next-state logic
    always_comb begin
        bank_d = bank_q;
        unique case (bank_q)
            BANK_LO: if (st_we && wr_data_i[BANK_BIT])  bank_d = BANK_HI; // SELECT_HI
            BANK_HI: if (st_we && !wr_data_i[BANK_BIT]) bank_d = BANK_LO; // SELECT_LO
            default: bank_d = BANK_LO;
        endcase
    end

    // State register plus the rest of the status byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q   <= BANK_LO;
            status_q <= '0;
        end else begin
            bank_q <= bank_d;
            if (st_we) status_q <= wr_data_i;
        end
    end

    assign status_view = (status_q & ~BANK_MASK) |
                         ((bank_q == BANK_HI) ? BANK_MASK : '0);

    // Read output mux
    always_comb begin
        rd_data_o = '0;
        unique case (region)
            REG_SFR: begin
                if (sfr_slot == SLOT_STATUS)
                    rd_data_o = status_view;
                else if (sfr_slot == SLOT_PORT)
                    rd_data_o = (bank_q == BANK_LO) ? DATA_W'(pin_in_i)
                                                    : DATA_W'(dir_val);
            end
            REG_GPR, REG_MIRROR: rd_data_o = gpr_rdata;
            REG_HOLE: rd_data_o = '0;
            default: rd_data_o = '0;
        endcase
    end

    assert_bank_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |=> ((bank_q == BANK_HI) == $past(wr_data_i[BANK_BIT])));
    assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_we |=> $stable(bank_q));
    assert_hole_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (region == REG_HOLE) |-> (rd_data_o == '0));
    assert_hole_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && region == REG_HOLE) |=>
            ($stable(pin_out_o) && $stable(pin_oe_o) && $stable(bank_q) && $stable(status_q)));
    assert_port_write_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(lat_we && dir_we));
endmodule

// File: tb/banked_dmem_tb.sv
module banked_dmem_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    banked_dmem u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_data_o(rd_data), .pin_in_i(pin_in),
        .pin_out_o(pin_out), .pin_oe_o(pin_oe)
    );

    // {req, wr, addr, wdata, pin, expected read}
    localparam int NV = 24;
    localparam logic [35:0] VEC [NV] = '{
        {4'd3, 1'b0, 7'h03, 8'h00, 8'h00, 8'h00}, // R3 status in bank 0
        {4'd4, 1'b1, 7'h0C, 8'hA5, 8'h00, 8'h00}, // R4 first RAM byte
        {4'd4, 1'b1, 7'h4F, 8'h3C, 8'h00, 8'h00}, // R4 last RAM byte
        {4'd4, 1'b0, 7'h0C, 8'h00, 8'h00, 8'hA5}, // R4
        {4'd4, 1'b0, 7'h4F, 8'h00, 8'h00, 8'h3C}, // R4
        {4'd6, 1'b1, 7'h50, 8'h77, 8'h00, 8'h00}, // R6 write lower hole
        {4'd6, 1'b0, 7'h50, 8'h00, 8'h00, 8'h00}, // R6
        {4'd9, 1'b0, 7'h05, 8'h00, 8'h5A, 8'h5A}, // R9 pins read
        {4'd7, 1'b0, 7'h04, 8'h00, 8'h00, 8'h00}, // R7 unimplemented slot
        {4'd3, 1'b1, 7'h03, 8'h20, 8'h00, 8'h00}, // R3 select bank 1
        {4'd3, 1'b0, 7'h03, 8'h00, 8'h00, 8'h20}, // R3 status at 83h
        {4'd1, 1'b0, 7'h05, 8'h00, 8'h5A, 8'hFF}, // R1 85h is direction
        {4'd8, 1'b1, 7'h05, 8'h0F, 8'h00, 8'h00}, // R8 write direction
        {4'd8, 1'b0, 7'h05, 8'h00, 8'h00, 8'h0F}, // R8 readback
        {4'd5, 1'b0, 7'h0C, 8'h00, 8'h00, 8'hA5}, // R5 8Ch mirrors 0Ch
        {4'd5, 1'b1, 7'h4F, 8'hC3, 8'h00, 8'h00}, // R5 write CFh
        {4'd6, 1'b1, 7'h50, 8'h99, 8'h00, 8'h00}, // R6 write upper hole
        {4'd6, 1'b0, 7'h50, 8'h00, 8'h00, 8'h00}, // R6
        {4'd3, 1'b1, 7'h03, 8'h00, 8'h00, 8'h00}, // R3 back to bank 0
        {4'd5, 1'b0, 7'h4F, 8'h00, 8'h00, 8'hC3}, // R5 4Fh sees CFh write
        {4'd9, 1'b0, 7'h05, 8'h00, 8'h81, 8'h81}, // R9 other pin pattern
        {4'd9, 1'b1, 7'h05, 8'hAA, 8'h81, 8'h00}, // R9 write latch
        {4'd7, 1'b1, 7'h04, 8'h55, 8'h00, 8'h00}, // R7 write ignored
        {4'd7, 1'b0, 7'h04, 8'h00, 8'h00, 8'h00}  // R7
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [6:0] a, input logic [7:0] d, input logic [7:0] p);
        @(negedge clk);
        wr_en = w; addr = a; wr_data = d; pin_in = p;
        #1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R2 reset state
        step(1'b0, 7'h03, 8'h00, 8'h00);
        check("R2 status", rd_data, 8'h00);
        check("R2 pin_oe", pin_oe, 8'h00);
        check("R2 pin_out", pin_out, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][31], VEC[i][30:24], VEC[i][23:16], VEC[i][15:8]);
            if (!VEC[i][31])
                check($sformatf("R%0d vec%0d", VEC[i][35:32], i), rd_data, VEC[i][7:0]);
        end

        // R9 latch and R8 direction at the pins
        step(1'b0, 7'h04, 8'h00, 8'h00);
        check("R9 pin_out", pin_out, 8'hAA);
        check("R8 pin_oe", pin_oe, 8'hF0);

        // R3 bank switch delayed by one cycle; all status bits stored
        step(1'b1, 7'h03, 8'hFF, 8'h00);
        check("R3 old value in write cycle", rd_data, 8'h00);
        step(1'b0, 7'h03, 8'h00, 8'h00);
        check("R3 full byte", rd_data, 8'hFF);
        step(1'b0, 7'h05, 8'h00, 8'h3C);
        check("R1 bank1 05h", rd_data, 8'h0F);
        step(1'b1, 7'h03, 8'h00, 8'h00);
        check("R1 bank1 still in write cycle", rd_data, 8'hFF);
        step(1'b0, 7'h05, 8'h00, 8'h3C);
        check("R1 bank0 05h", rd_data, 8'h3C);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule